// File: doc/BRIEF.md
# Microinstruction-Driven Register Datapath

A 32-bit datapath that carries out one horizontal microinstruction per clock. Each microinstruction names two source registers and one destination register in a small register file. It also selects the operand for the second source: either the register read or a 16-bit immediate sign-extended to the datapath width. Three functional units see the operands: an adder/subtractor, a truth-table logic unit and a bidirectional shifter/rotator. Each unit has its own enable bit, and the enabled output is written back to the destination register on the next rising edge when the write bit is set.

The sign-extended immediate serves as a constant operand (`R1 <- R1 - 5`), as a shift amount (0xFFFE is -2, a left shift by two) or as a mask (0x00FF). The logic unit takes a 4-bit code that is the truth table of the wanted two-input function, so a new function needs no new opcode.

Microinstructions arrive on a valid/ready port. Ready is held high at all times because every microinstruction completes in its own cycle, so the port never applies back-pressure. A microinstruction is taken on every rising edge where `uop_valid` is high. The combinational result is presented with `res_valid`, which equals `uop_valid`. The result side has no ready input: a consumer that cannot take a result must hold `uop_valid` low.

Top module: `ucode_datapath`

## Requirements
- R1: After reset, all 8 registers read as zero.
- R2: A register write happens at the rising clock edge only when `uop_valid` and `uop_wr_en` are both high, and it stores `res_data` into register `uop_z`. Register reads are combinational. When `uop_valid` is low, no register changes, even if `uop_wr_en` is high.
- R3: When `uop_imm_en` is 1, the second operand is `uop_imm` sign-extended from 16 to 32 bits (bit 15 copied upward). When it is 0, the second operand is register `uop_y`.
- R4: With `uop_arith_en` set, the arithmetic unit gives first operand + second operand when `uop_sub` is 0. It gives first operand - second operand when `uop_sub` is 1. Both are taken modulo 2^32.
- R5: With `uop_logic_en` set, result bit i equals `uop_lfunc[2*a_i + b_i]`, where a is the first operand and b is the second. So code 0xE is OR, 0x8 is AND, 0x6 is XOR and 0xC passes the first operand through.
- R6: With `uop_shift_en` set, the first operand is shifted by the second operand read as a signed 32-bit amount. A positive amount shifts right and a negative amount shifts left. `uop_stype` selects the shift: 0 is logical, 1 is arithmetic (sign fill on right shifts), and 2 or 3 is a rotate right by the amount modulo 32. A negative rotate amount is therefore a left rotate.
- R7: For logical and arithmetic shifts with an amount magnitude of 32 or more, the result is zero. The one exception is an arithmetic right shift, which gives 32 copies of the operand's sign bit.
- R8: With no unit enabled the result is zero. With several units enabled, the result is the bitwise OR of the enabled units' outputs.
- R9: The fields of a disabled unit (`uop_sub`, `uop_lfunc`, `uop_stype`) have no effect on `res_data`.
- R10: `uop_ready` is always 1, and `res_valid` equals `uop_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | Microinstruction present this cycle |
| uop_ready | output | 1 | Always 1; the datapath never stalls |
| uop_x | input | 3 | First source register number |
| uop_y | input | 3 | Second source register number |
| uop_z | input | 3 | Destination register number |
| uop_wr_en | input | 1 | Write result to destination |
| uop_imm_en | input | 1 | Use immediate as second operand |
| uop_imm | input | 16 | Immediate, sign-extended |
| uop_arith_en | input | 1 | Adder/subtractor enable |
| uop_sub | input | 1 | 0 add, 1 subtract |
| uop_logic_en | input | 1 | Logic unit enable |
| uop_lfunc | input | 4 | Truth-table function code |
| uop_shift_en | input | 1 | Shift unit enable |
| uop_stype | input | 2 | 0 logical, 1 arithmetic, 2/3 rotate |
| res_valid | output | 1 | Result valid, equal to `uop_valid` |
| res_data | output | 32 | Combined unit result |

## Verification
The bench builds the block with its defaults: 32-bit data, 8 registers and a 16-bit immediate. With these values, a sign-extended immediate reaches shift magnitudes on both sides of the 32 boundary. It can also land exactly on zero and on large negative amounts, so saturation and rotate wrap are both reached.

Eight registers are few enough that random source and destination numbers often coincide. This exercises read-after-write and self-subtraction. The directed part rebuilds the worked sequences:
- packing constants with shifts and ORs;
- rotate by -12;
- arithmetic shift by +16;
- logical shift by -4;
- OR, AND and XOR codes;
- byte unpack;
- averaging.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {
    SH_LOGICAL = 2'b00,
    SH_ARITH   = 2'b01,
    SH_ROTATE  = 2'b10,
    SH_ROTATE2 = 2'b11
  } shift_kind_t;

  localparam int unsigned LFUNC_W = 4;
  localparam logic [LFUNC_W-1:0] LF_PASS_A = 4'hC;
  localparam logic [LFUNC_W-1:0] LF_AND    = 4'h8;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [AW-1:0]     ra_x,
  input  logic [AW-1:0]     ra_y,
  output logic [DATA_W-1:0] rd_x,
  output logic [DATA_W-1:0] rd_y
);
  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd_x = mem[ra_x];
  assign rd_y = mem[ra_y];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ra_x == wa) |=> (!$stable(ra_x) || rd_x == $past(wd))) else $error("write lost"); // R2

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (!$stable(ra_y) || $stable(rd_y))) else $error("register changed without write"); // R2
endmodule

// File: rtl/dp_logic.sv
module dp_logic #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]         a,
  input  logic [DATA_W-1:0]         b,
  input  logic [dp_pkg::LFUNC_W-1:0] code,
  output logic [DATA_W-1:0]         y
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign y[i] = code[{a[i], b[i]}];
  end

  always_comb begin
    if (code == dp_pkg::LF_AND) begin
      AST_LOGIC_AND: assert (y == (a & b)) else $error("and code mismatch"); // R5
    end
    if (code == dp_pkg::LF_PASS_A) begin
      AST_LOGIC_PASS: assert (y == a) else $error("pass code mismatch"); // R5
    end
  end
endmodule

// File: rtl/dp_shift.sv
module dp_shift #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SW    = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   amt,
  input  dp_pkg::shift_kind_t kind,
  output logic [DATA_W-1:0]   y
);
  logic              neg;
  logic [DATA_W-1:0] mag_full;
  logic              big;
  logic [SW-1:0]     mag;
  logic [SW-2:0]     rot;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0] rotated;

  assign neg      = amt[DATA_W-1];
  assign mag_full = neg ? (~amt + 1'b1) : amt;
  assign big      = (mag_full >= DATA_W[DATA_W-1:0]);
  assign mag      = big ? SW'(DATA_W) : mag_full[SW-1:0];
  assign rot      = amt[SW-2:0];
  assign dbl      = {a, a} >> rot;
  assign rotated  = dbl[DATA_W-1:0];

  always_comb begin
    unique case (kind)
      dp_pkg::SH_ROTATE, dp_pkg::SH_ROTATE2: y = rotated;
      dp_pkg::SH_ARITH:  y = neg ? (a << mag) : DATA_W'($signed(a) >>> mag);
      default:           y = neg ? (a << mag) : (a >> mag);
    endcase
  end

  always_comb begin
    if (kind[1] && amt == '0) begin
      AST_ROT_ZERO: assert (y == a) else $error("rotate by zero changed data"); // R6
    end
    if (kind == dp_pkg::SH_LOGICAL && big) begin
      AST_SHIFT_SAT: assert (y == '0) else $error("oversized shift not zero"); // R7
    end
  end
endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 8,
  parameter int unsigned IMM_W  = 16,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uop_valid,
  output logic              uop_ready,
  input  logic [AW-1:0]     uop_x,
  input  logic [AW-1:0]     uop_y,
  input  logic [AW-1:0]     uop_z,
  input  logic              uop_wr_en,
  input  logic              uop_imm_en,
  input  logic [IMM_W-1:0]  uop_imm,
  input  logic              uop_arith_en,
  input  logic              uop_sub,
  input  logic              uop_logic_en,
  input  logic [3:0]        uop_lfunc,
  input  logic              uop_shift_en,
  input  logic [1:0]        uop_stype,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  logic [DATA_W-1:0] rd_x, rd_y, op_b;
  logic [DATA_W-1:0] arith_r, logic_r, shift_r, result;
  logic              wr_fire;

  assign uop_ready = 1'b1;
  assign res_valid = uop_valid;
  assign wr_fire   = uop_valid && uop_wr_en;

  dp_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .wa(uop_z), .wd(result),
    .ra_x(uop_x), .ra_y(uop_y), .rd_x(rd_x), .rd_y(rd_y)
  );

  assign op_b    = uop_imm_en ? {{(DATA_W-IMM_W){uop_imm[IMM_W-1]}}, uop_imm} : rd_y;
  assign arith_r = uop_sub ? (rd_x - op_b) : (rd_x + op_b);

  dp_logic #(.DATA_W(DATA_W)) u_logic (
    .a(rd_x), .b(op_b), .code(uop_lfunc), .y(logic_r)
  );

  dp_shift #(.DATA_W(DATA_W)) u_shift (
    .a(rd_x), .amt(op_b), .kind(dp_pkg::shift_kind_t'(uop_stype)), .y(shift_r)
  );

  assign result = (uop_arith_en ? arith_r : '0)
                | (uop_logic_en ? logic_r : '0)
                | (uop_shift_en ? shift_r : '0);
  assign res_data = result;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!uop_arith_en && !uop_logic_en && !uop_shift_en) |-> res_data == '0) else $error("idle result"); // R8

  AST_SELF_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_arith_en && !uop_logic_en && !uop_shift_en && uop_sub && !uop_imm_en && uop_x == uop_y)
      |-> res_data == '0) else $error("x-x nonzero"); // R4

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (uop_x != $past(uop_z) || rd_x == $past(res_data))) else $error("readback"); // R2

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == uop_valid && uop_ready) else $error("handshake"); // R10
endmodule

// File: tb/tb_ucode_datapath.sv
module tb_ucode_datapath;
  logic clk = 0, rst_n = 0;
  logic uop_valid, uop_ready, uop_wr_en, uop_imm_en, uop_arith_en, uop_sub;
  logic uop_logic_en, uop_shift_en, res_valid;
  logic [2:0] uop_x, uop_y, uop_z;
  logic [15:0] uop_imm;
  logic [3:0] uop_lfunc;
  logic [1:0] uop_stype;
  logic [31:0] res_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m [8];
  logic [31:0] last;

  always #4 clk = ~clk;

  ucode_datapath dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_shift(logic [31:0] a, logic [31:0] b, logic [1:0] t);
    int amt = $signed(b);
    logic [31:0] o = '0;
    if (t[1]) begin
      int r = amt & 31;
      for (int i = 0; i < 32; i++) o[i] = a[(i + r) % 32];
    end else if (amt < 0) begin
      if (amt > -32) o = a << (-amt);
    end else if (amt >= 32) begin
      o = (t == 2'd1 && a[31]) ? 32'hFFFF_FFFF : 32'h0;
    end else begin
      for (int i = 0; i < 32; i++)
        o[i] = (i + amt < 32) ? a[i + amt] : (t == 2'd1 ? a[31] : 1'b0);
    end
    return o;
  endfunction

  function automatic logic [31:0] ref_res();
    logic [31:0] a = m[uop_x];
    logic [31:0] b = uop_imm_en ? 32'($signed(uop_imm)) : m[uop_y];
    logic [31:0] o = '0, lg;
    if (uop_arith_en) o |= uop_sub ? a - b : a + b;
    if (uop_logic_en) begin
      for (int i = 0; i < 32; i++) lg[i] = uop_lfunc[2*a[i] + b[i]];
      o |= lg;
    end
    if (uop_shift_en) o |= ref_shift(a, b, uop_stype);
    return o;
  endfunction

  // inputs driven 1ns after posedge; compare at negedge; model written then
  task automatic issue(string tag, bit v, int x, int y, int z, bit we, bit ie, int imm,
                       bit ae, bit sb, bit le, int lf, bit se, int st);
    logic [31:0] e;
    uop_valid = v; uop_x = 3'(x); uop_y = 3'(y); uop_z = 3'(z); uop_wr_en = we;
    uop_imm_en = ie; uop_imm = 16'(imm); uop_arith_en = ae; uop_sub = sb;
    uop_logic_en = le; uop_lfunc = 4'(lf); uop_shift_en = se; uop_stype = 2'(st);
    @(negedge clk);
    e = ref_res();
    last = res_data;
    check(tag, res_data, e);
    check("R10", {31'b0, res_valid}, {31'b0, v});
    check("R10", {31'b0, uop_ready}, 32'd1);
    if (v && we) m[z] = e;
    @(posedge clk); #1;
  endtask

  // read register r through logic pass-through code C
  task automatic peek(string tag, int r);
    issue(tag, 1, r, 0, 0, 0, 0, 0, 0, 0, 1, 12, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    uop_valid = 0; uop_x = 0; uop_y = 0; uop_z = 0; uop_wr_en = 0; uop_imm_en = 0;
    uop_imm = 0; uop_arith_en = 0; uop_sub = 0; uop_logic_en = 0; uop_lfunc = 0;
    uop_shift_en = 0; uop_stype = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int r = 0; r < 8; r++) begin peek("R1", r); check("R1", last, 32'h0); end
    // R3: build 87654321 in r1 with sign-extended immediates
    issue("R3", 1, 0, 0, 1, 1, 1, 16'h8765, 1, 0, 0, 0, 0, 0);
    check("R3", last, 32'hFFFF_8765);
    issue("R6", 1, 1, 0, 1, 1, 1, 16'hFFF0, 0, 0, 0, 0, 1, 0);
    issue("R5", 1, 1, 0, 1, 1, 1, 16'h4321, 0, 0, 1, 14, 0, 0);
    check("R5", last, 32'h8765_4321);
    issue("R6", 1, 1, 0, 2, 0, 1, 16'hFFF4, 0, 0, 0, 0, 1, 2);
    check("R6", last, 32'h5432_1876);
    issue("R6", 1, 1, 0, 2, 0, 1, 16'd20, 0, 0, 0, 0, 1, 3);
    check("R6", last, 32'h5432_1876);
    issue("R6", 1, 1, 0, 2, 0, 1, 16'd16, 0, 0, 0, 0, 1, 1);
    check("R6", last, 32'hFFFF_8765);
    issue("R6", 1, 1, 0, 2, 0, 1, 16'hFFFC, 0, 0, 0, 0, 1, 0);
    check("R6", last, 32'h7654_3210);
    issue("R7", 1, 1, 0, 2, 0, 1, 16'd40, 0, 0, 0, 0, 1, 1);
    check("R7", last, 32'hFFFF_FFFF);
    issue("R7", 1, 1, 0, 2, 0, 1, 16'd32, 0, 0, 0, 0, 1, 0);
    check("R7", last, 32'h0);
    issue("R7", 1, 1, 0, 2, 0, 1, 16'hFFE0, 0, 0, 0, 0, 1, 1);
    check("R7", last, 32'h0);
    // r2 = 0F0F0F0F, r3 = 12345678
    issue("R3", 1, 0, 0, 2, 1, 1, 16'h0F0F, 1, 0, 0, 0, 0, 0);
    issue("R6", 1, 2, 0, 2, 1, 1, 16'hFFF0, 0, 0, 0, 0, 1, 0);
    issue("R5", 1, 2, 0, 2, 1, 1, 16'h0F0F, 0, 0, 1, 14, 0, 0);
    issue("R3", 1, 0, 0, 3, 1, 1, 16'h1234, 1, 0, 0, 0, 0, 0);
    issue("R6", 1, 3, 0, 3, 1, 1, 16'hFFF0, 0, 0, 0, 0, 1, 0);
    issue("R5", 1, 3, 0, 3, 1, 1, 16'h5678, 0, 0, 1, 14, 0, 0);
    issue("R5", 1, 3, 2, 4, 0, 0, 0, 0, 0, 1, 14, 0, 0); check("R5", last, 32'h1F3F_5F7F);
    issue("R5", 1, 3, 2, 4, 0, 0, 0, 0, 0, 1, 8, 0, 0);  check("R5", last, 32'h0204_0608);
    issue("R5", 1, 3, 2, 4, 0, 0, 0, 0, 0, 1, 6, 0, 0);  check("R5", last, 32'h1D3B_5977);
    // byte unpack: (r3 >> 8) & FF = 0x56
    issue("R6", 1, 3, 0, 5, 1, 1, 16'd8, 0, 0, 0, 0, 1, 0);
    issue("R5", 1, 5, 0, 5, 1, 1, 16'h00FF, 0, 0, 1, 8, 0, 0); check("R5", last, 32'h56);
    // R4: subtract immediate 5, average (0x56 + 0x0F0F0F0F)>>1
    issue("R4", 1, 5, 0, 6, 1, 1, 5, 1, 1, 0, 0, 0, 0); check("R4", last, 32'h51);
    issue("R4", 1, 5, 2, 6, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    issue("R6", 1, 6, 0, 6, 1, 1, 1, 0, 0, 0, 0, 1, 1); check("R6", last, 32'h0787_87B2);
    // R2: write with valid low is dropped
    issue("R2", 0, 0, 0, 6, 1, 1, 16'h7777, 1, 0, 0, 0, 0, 0);
    peek("R2", 6); check("R2", last, 32'h0787_87B2);
    // R8: nothing enabled, then all enabled
    issue("R8", 1, 1, 2, 0, 0, 0, 0, 0, 1, 0, 15, 0, 3); check("R8", last, 32'h0);
    issue("R8", 1, 1, 2, 7, 1, 0, 0, 1, 0, 1, 6, 1, 2);
    // R9: random stream covering disabled-field don't-cares and combinations
    for (int k = 0; k < 4000; k++) begin
      int im = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 80) - 40 : $urandom;
      issue("R9", $urandom_range(0, 9) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1), im,
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 3));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule